// File: doc/BRIEF.md
# Segmented Two's Complement Multiplier (51 x 51)

This block multiplies two signed operands and delivers the full-width signed product from a register. The work is split in two. An unsigned core multiplies the operands with their sign bits removed. A signed correction then adds in the sign-bit contributions.

The unsigned core cuts the magnitude bits of each operand into three equal segments. It forms all nine cross products with small registered unsigned multipliers. A three-level addition tree then combines the nine products. Products of equal size are paired first, and the group that arrives last is added at the end.

The signed correction holds each operand's sign-weighted terms as complemented AND rows. Two adders combine them, and each sign bit enters one of these adders as its carry-in. A product leaves the block three clock edges after its operands are presented. A new operand pair can be accepted on every cycle.

Top module: `bw_seg_mult`

## Requirements
- R1: On every clock edge the block captures `op_a` and `op_b`. `prod` shows their exact two's complement product, taken modulo 2^(2*OP_W), after the third rising edge following capture. This holds for every operand pair, and a new pair may be applied every cycle.
- R2: While `rst_n` is low at a rising edge, every pipeline register and `prod` are cleared to zero. After release, `prod` stays zero for the first two edges, and the third edge shows the product of the operands captured at the first edge.
- R3: For non-negative operands, the product equals the unsigned product of the low OP_W-1 bits. Those bits are split into three segments of ceil((OP_W-1)/3) bits at offsets 0, 1x and 2x the segment width, with the top segment zero-filled.
- R4: Carries between the diagonal, offset-by-one-segment and offset-by-two-segment groups reach the upper product bits. Operands whose magnitude bits are all ones give exact products.
- R5: Operands with a set sign bit are corrected by complemented AND rows at weight 2^(OP_W-1), with each sign bit used as a carry-in. Mixed-sign and negative-by-negative pairs give exact products. When both sign bits are clear, the correction changes nothing.
- R6: The most negative value times itself gives +2^(2*OP_W-2). The most negative value times the most positive value gives the exact negative result.
- R7: Zero times any operand gives zero. Minus one times any operand gives its negation, and minus one times minus one gives one.
- R8: The same RTL built with OP_W = 7 (two-bit segments) gives the exact product for all 16384 operand pairs.
- R9: When neither operand is zero, bit 2*OP_W-1 of the product equals the XOR of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | OP_W | Multiplicand, two's complement |
| op_b | input | OP_W | Multiplier, two's complement |
| prod | output | 2*OP_W | Registered signed product, three edges after capture |

## Verification
The bench builds two copies of the block side by side. The first uses the default OP_W of 51. Its 17-bit segments receive directed extreme values plus random operands, biased toward small magnitudes, values near the limits, and a single live segment.

The second uses OP_W = 7, which gives two-bit segments that fill the magnitude field exactly. That makes every operand pair reachable, so each sign combination and each carry path of the tree is covered exhaustively. The wide copy then confirms that the same structure holds at full width.

// File: rtl/bw_mul_pkg.sv
// Package: shared constants for the segmented multiplier.
// Assumes the unsigned core is always cut into exactly three segments.
package bw_mul_pkg;

    localparam int NSEG = 3;

    // Segment width that covers lo_w magnitude bits with NSEG segments.
    function automatic int seg_width(input int lo_w);
        return (lo_w + NSEG - 1) / NSEG;
    endfunction

endpackage

// File: rtl/bw_seg_mul.sv
// Module: bw_seg_mul
// Unsigned W x W segment multiplier. Its operands are registered on input
// and its product is registered on output, so the latency is two edges.
// Assumes a synchronous active-low reset that clears both stages.
module bw_seg_mul #(
    parameter int W = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int PW = 2 * W;

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    // Operand capture stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a;
            b_q <= b;
        end
    end

    // Product stage.
    always_ff @(posedge clk) begin
        if (!rst_n) p <= '0;
        else        p <= PW'(a_q) * PW'(b_q);
    end

endmodule

// File: rtl/bw_usum.sv
// Module: bw_usum
// Sums the nine segment products of the unsigned core. The product at
// index i*3+j is Xi*Yj.
//   Level 1 pairs equal-length terms: the two offset-one concatenations,
//           and the two offset-two products.
//   Level 2 adds the offset-two sum into the diagonal concatenation.
//   Level 3 adds the offset-one sum, which arrives last.
// Assumes three segments; the output is truncated to U_W bits.
module bw_usum #(
    parameter int SEG_W = 17,
    parameter int U_W   = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [8:0][2*SEG_W-1:0]  pp,
    output logic [U_W-1:0]           u
);

    localparam int PW    = 2 * SEG_W;
    localparam int SUM_W = 6 * SEG_W;

    logic [SUM_W-1:0] diag;
    logic [2*PW-1:0]  mid_hi;
    logic [2*PW-1:0]  mid_lo;
    logic [2*PW:0]    mid_sum;
    logic [PW:0]      far_sum;
    logic [SUM_W-1:0] lvl2;
    logic [SUM_W-1:0] lvl3;

    // Level 1: pair equal-length terms.
    always_comb begin
        diag    = {pp[8], pp[4], pp[0]};
        mid_hi  = {pp[7], pp[3]};
        mid_lo  = {pp[5], pp[1]};
        mid_sum = {1'b0, mid_hi} + {1'b0, mid_lo};
        far_sum = {1'b0, pp[6]} + {1'b0, pp[2]};
    end

    // Levels 2 and 3: early group first, late offset-one group last.
    always_comb begin
        lvl2 = diag + (SUM_W'(far_sum) << (2 * SEG_W));
        lvl3 = lvl2 + (SUM_W'(mid_sum) << SEG_W);
    end

    assign u = lvl3[U_W-1:0];

    generate
        if (SUM_W > U_W) begin : g_fit
            AST_USUM_FITS: assert property (@(posedge clk) disable iff (!rst_n)
                lvl3[SUM_W-1:U_W] == '0); // R3
        end
    endgenerate

endmodule

// File: rtl/bw_sign_fix.sv
// Module: bw_sign_fix
// Combinational signed correction. Each operand's sign-weighted row is held
// as complemented AND terms at weight 2^(OP_W-1), together with its sign at
// weight 2^(2*OP_W-2).
// The first adder sums the two rows with x's sign as carry-in. The second
// adds that result to the upper part of the unsigned sum, extended by the
// sign-dependent top bits, with y's sign as carry-in.
// Assumes u is the unsigned product of the two magnitude fields.
module bw_sign_fix #(
    parameter int OP_W = 51
) (
    input  logic                xs,
    input  logic                ys,
    input  logic [OP_W-2:0]     xl,
    input  logic [OP_W-2:0]     yl,
    input  logic [2*OP_W-3:0]   u,
    output logic [2*OP_W-1:0]   p
);

    localparam int LO_W = OP_W - 1;
    localparam int U_W  = 2 * LO_W;

    logic [OP_W-1:0] row_x;
    logic [OP_W-1:0] row_y;
    logic [OP_W:0]   corr;
    logic [OP_W:0]   base_hi;
    logic [OP_W:0]   hi;

    // Correction rows and the first adder (carry-in: x sign).
    always_comb begin
        row_x = {xs, {LO_W{xs}} & ~yl};
        row_y = {ys, {LO_W{ys}} & ~xl};
        corr  = {1'b0, row_x} + {1'b0, row_y} + (OP_W + 1)'(xs);
    end

    // Second adder on the upper part (carry-in: y sign); the low part passes through.
    always_comb begin
        base_hi = {xs ^ ys, xs & ys, u[U_W-1:LO_W]};
        hi      = base_hi + corr + (OP_W + 1)'(ys);
        p       = {hi, u[LO_W-1:0]};
    end

endmodule

// File: rtl/bw_seg_mult.sv
// Module: bw_seg_mult
// Top of the segmented two's complement multiplier. Nine registered
// segment multipliers form the unsigned core. The signs and magnitude
// fields travel alongside them in a matching two-stage delay, then the
// correction is added and the product is registered.
// Latency is three edges. Assumes OP_W >= 4.
module bw_seg_mult
    import bw_mul_pkg::*;
#(
    parameter int OP_W = 51
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_a,
    input  logic [OP_W-1:0]     op_b,
    output logic [2*OP_W-1:0]   prod
);

    localparam int LO_W  = OP_W - 1;
    localparam int SEG_W = seg_width(LO_W);
    localparam int EXT_W = NSEG * SEG_W;
    localparam int U_W   = 2 * LO_W;
    localparam int P_W   = 2 * OP_W;

    logic [EXT_W-1:0] xe;
    logic [EXT_W-1:0] ye;
    logic [NSEG*NSEG-1:0][2*SEG_W-1:0] pp;

    logic            xs_d1, ys_d1, xs_d2, ys_d2;
    logic [LO_W-1:0] xl_d1, yl_d1, xl_d2, yl_d2;
    logic [U_W-1:0]  u_sum;
    logic [P_W-1:0]  nxt;
    logic [1:0]      warm;

    // Zero-fill the magnitude fields up to three whole segments.
    assign xe = EXT_W'(op_a[LO_W-1:0]);
    assign ye = EXT_W'(op_b[LO_W-1:0]);

    generate
        for (genvar gi = 0; gi < NSEG; gi++) begin : g_row
            for (genvar gj = 0; gj < NSEG; gj++) begin : g_col
                bw_seg_mul #(.W(SEG_W)) u_seg (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .a     (xe[gi*SEG_W +: SEG_W]),
                    .b     (ye[gj*SEG_W +: SEG_W]),
                    .p     (pp[gi*NSEG + gj])
                );
            end
        end
    endgenerate

    // Delay signs and magnitudes to line up with the segment products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs_d1 <= 1'b0; ys_d1 <= 1'b0; xs_d2 <= 1'b0; ys_d2 <= 1'b0;
            xl_d1 <= '0;   yl_d1 <= '0;   xl_d2 <= '0;   yl_d2 <= '0;
        end else begin
            xs_d1 <= op_a[OP_W-1];
            ys_d1 <= op_b[OP_W-1];
            xl_d1 <= op_a[LO_W-1:0];
            yl_d1 <= op_b[LO_W-1:0];
            xs_d2 <= xs_d1;
            ys_d2 <= ys_d1;
            xl_d2 <= xl_d1;
            yl_d2 <= yl_d1;
        end
    end

    bw_usum #(.SEG_W(SEG_W), .U_W(U_W)) u_usum (
        .clk   (clk),
        .rst_n (rst_n),
        .pp    (pp),
        .u     (u_sum)
    );

    bw_sign_fix #(.OP_W(OP_W)) u_fix (
        .xs (xs_d2),
        .ys (ys_d2),
        .xl (xl_d2),
        .yl (yl_d2),
        .u  (u_sum),
        .p  (nxt)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) prod <= '0;
        else        prod <= nxt;
    end

    // Edges since reset release, saturating; used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    logic signed [P_W-1:0] a_x;
    logic signed [P_W-1:0] b_x;
    assign a_x = {{OP_W{op_a[OP_W-1]}}, op_a};
    assign b_x = {{OP_W{op_b[OP_W-1]}}, op_b};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> prod == '0); // R2
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> $signed(prod) == $past(a_x, 3) * $past(b_x, 3)); // R1
    AST_CORE_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        u_sum == U_W'(xl_d2) * U_W'(yl_d2)); // R3
    AST_NONNEG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!xs_d2 && !ys_d2) |-> nxt == P_W'(u_sum)); // R5
    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(op_a, 3) != '0 && $past(op_b, 3) != '0)
        |-> prod[P_W-1] == $past(op_a[OP_W-1] ^ op_b[OP_W-1], 3)); // R9

endmodule

// File: tb/sim_bw_seg_mult.sv
module sim_bw_seg_mult;

    localparam int BW = 51;
    localparam int SW = 7;
    localparam int NVEC = 16384;
    localparam logic [BW-1:0] MINV = {1'b1, {(BW-1){1'b0}}};
    localparam logic [BW-1:0] MAXV = {1'b0, {(BW-1){1'b1}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BW-1:0]   a0 = '0, b0 = '0;
    logic [2*BW-1:0] p0;
    logic [SW-1:0]   a1 = '0, b1 = '0;
    logic [2*SW-1:0] p1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bw_seg_mult #(.OP_W(BW)) u0 (.clk(clk), .rst_n(rst_n), .op_a(a0), .op_b(b0), .prod(p0));
    bw_seg_mult #(.OP_W(SW)) u1 (.clk(clk), .rst_n(rst_n), .op_a(a1), .op_b(b1), .prod(p1));

    function automatic logic [2*BW-1:0] mul_big(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic signed [2*BW-1:0] ax, bx;
        ax = {{BW{a[BW-1]}}, a};
        bx = {{BW{b[BW-1]}}, b};
        return ax * bx;
    endfunction

    function automatic logic [2*SW-1:0] mul_small(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic signed [2*SW-1:0] ax, bx;
        ax = {{SW{a[SW-1]}}, a};
        bx = {{SW{b[SW-1]}}, b};
        return ax * bx;
    endfunction

    function automatic string tag_of(input logic [BW-1:0] a, input logic [BW-1:0] b);
        if ((a == MINV && (b == MINV || b == MAXV)) || (b == MINV && a == MAXV))
            return "R6 extreme values";
        if (a == '0 || b == '0 || a == '1 || b == '1)
            return "R7 zero or minus one";
        if (a[BW-2:0] == '1 || b[BW-2:0] == '1)
            return "R4 full-segment carries";
        if (!a[BW-1] && !b[BW-1])
            return "R1 R3 unsigned core";
        return "R1 R5 signed correction";
    endfunction

    task automatic check(input string tag, input logic [2*BW-1:0] act, input logic [2*BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pick(input int k, output logic [BW-1:0] a, output logic [BW-1:0] b);
        logic [63:0] r1, r2;
        r1 = {$urandom(), $urandom()};
        r2 = {$urandom(), $urandom()};
        case (k)
            0:  begin a = MINV;     b = MINV;     end
            1:  begin a = MINV;     b = MAXV;     end
            2:  begin a = MAXV;     b = MINV;     end
            3:  begin a = MAXV;     b = MAXV;     end
            4:  begin a = '0;       b = MINV;     end
            5:  begin a = '1;       b = '1;       end
            6:  begin a = '1;       b = MAXV;     end
            7:  begin a = MINV;     b = '1;       end
            8:  begin a = '0;       b = '0;       end
            9:  begin a = BW'(1);   b = '1;       end
            10: begin a = BW'(64'h1_FFFF); b = BW'(64'h3_FFFE_0000); end
            11: begin a = BW'(-64'sd12345); b = BW'(64'd987654321); end
            default: begin
                case ($urandom() % 4)
                    0: begin a = r1[BW-1:0]; b = r2[BW-1:0]; end
                    1: begin a = BW'($signed(r1[7:0])); b = BW'($signed(r2[7:0])); end
                    2: begin
                        a = r1[0] ? MINV + BW'(r1[5:1]) : MAXV - BW'(r1[5:1]);
                        b = r2[0] ? MINV + BW'(r2[5:1]) : MAXV - BW'(r2[5:1]);
                    end
                    default: begin
                        a = BW'(r1[16:0]) << (17 * (r1[40] ? 2 : (r1[41] ? 1 : 0)));
                        b = BW'(r2[16:0]) << (17 * (r2[40] ? 2 : (r2[41] ? 1 : 0)));
                        if (r1[50]) a = -a;
                        if (r2[50]) b = -b;
                    end
                endcase
            end
        endcase
    endtask

    initial begin
        logic [BW-1:0] qa [3];
        logic [BW-1:0] qb [3];
        logic [SW-1:0] sa [3];
        logic [SW-1:0] sb [3];
        bit qv [3];
        bit qr [3];
        logic [BW-1:0] na, nb;
        void'($urandom(32'd4242));

        // Reset with live inputs: product must stay zero (R2).
        a0 = MAXV; b0 = MINV; a1 = 7'h3F; b1 = 7'h40;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 during reset wide", p0, '0);
        check("R2 during reset narrow", {{(2*BW-2*SW){1'b0}}, p1}, '0);

        // Two leading zero slots model the post-release flush (R2).
        for (int i = 0; i < 3; i++) begin
            qa[i] = '0; qb[i] = '0; sa[i] = '0; sb[i] = '0;
            qv[i] = (i < 2); qr[i] = (i < 2);
        end
        rst_n = 1'b1;

        for (int k = 0; k < NVEC + 3; k++) begin
            if (qv[2]) begin
                check(qr[2] ? "R2 after release wide" : tag_of(qa[2], qb[2]),
                      p0, mul_big(qa[2], qb[2]));
                check(qr[2] ? "R2 after release narrow" : "R8 narrow exhaustive",
                      {{(2*BW-2*SW){1'b0}}, p1},
                      {{(2*BW-2*SW){1'b0}}, mul_small(sa[2], sb[2])});
                if (!qr[2] && qa[2] != '0 && qb[2] != '0)
                    check("R9 sign bit", {{(2*BW-1){1'b0}}, p0[2*BW-1]},
                          {{(2*BW-1){1'b0}}, qa[2][BW-1] ^ qb[2][BW-1]});
            end
            qa[2] = qa[1]; qb[2] = qb[1]; sa[2] = sa[1]; sb[2] = sb[1]; qv[2] = qv[1]; qr[2] = qr[1];
            qa[1] = qa[0]; qb[1] = qb[0]; sa[1] = sa[0]; sb[1] = sb[0]; qv[1] = qv[0]; qr[1] = qr[0];
            if (k < NVEC) begin
                pick(k, na, nb);
                a0 = na; b0 = nb;
                a1 = SW'(k >> SW); b1 = SW'(k);
                qv[0] = 1'b1;
            end else begin
                qv[0] = 1'b0;
            end
            qa[0] = a0; qb[0] = b0; sa[0] = a1; sb[0] = b1; qr[0] = 1'b0;
            @(negedge clk);
        end

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule